// File: doc/BRIEF.md
# ACPI PM1 Event and Timer Block

This block holds the fixed power-management event registers of a south bridge: a PM1 status register, a PM1 enable register, a PM1 control register and a free-running PM timer. It drives a level-sensitive system control interrupt (SCI). Firmware and the OS reach the registers through a small I/O window. Configuration space places that window: a 32-bit base value, masked down to a 64-byte boundary, gives its position, and a separate decode-enable bit switches it on or off. Inside the window only the low four address bits select a register, so the register set repeats every 16 bytes.

Three event inputs set their status bits: power button, RTC alarm and global-lock release. A fourth status bit is set each time the most significant bit of the timer counter changes. Status bits stay set until software writes a one to them. The SCI is high while any of these four status bits is set together with its enable bit. The counter advances only on cycles where the tick-enable input is high. When it wraps, the timer status bit is set.

A small two-state machine tracks whether a timer interrupt is armed. In state ARM_IDLE no timer interrupt is armed. The transition ARM_IDLE to ARM_LIVE ("arm") happens when the timer enable bit is set and the timer status bit is clear. The transition ARM_LIVE to ARM_IDLE ("disarm") happens when the timer enable bit is cleared or the timer status bit becomes set. The state is visible on `tmr_armed`.

Top module: `pm1_event_timer`

## Requirements
- R1: After reset, the status, enable and control registers read 0, the counter reads 0, and `sci` and `tmr_armed` are 0.
- R2: An access hits only when `cfg_decode_on` is 1 and the address with its low 6 bits cleared equals `cfg_pm_base` ANDed with 0xFFC0. The upper 16 bits of `cfg_pm_base` and its low 6 bits take no part in the compare. A write that misses changes nothing, and a read that misses returns 0.
- R3: Inside the window, only address bits [3:0] select the register. 16-bit registers sit at status 0x0, enable 0x2 and control 0x4, so base+0x12 reaches the enable register.
- R4: A 32-bit write (`io_dword`=1) to any offset changes no register.
- R5: These reads return 0: any unimplemented offset, a 16-bit read of offset 0x8, and a 32-bit read of any offset other than 0x8.
- R6: Each event input, when high at a clock edge, sets its status bit: timer at bit 0, global lock at bit 5, power button at bit 8, RTC at bit 10. The same bit positions are used in the enable register.
- R7: A 16-bit write to status clears each bit written as 1 and leaves each bit written as 0 unchanged. An event in the same cycle as a clear wins, so the bit stays set.
- R8: `sci` is 1 exactly when status AND enable is non-zero in bits {0,5,8,10}. Enable bits outside these four never raise it.
- R9: The counter increments by one at each clock edge where `tick_en` is 1, and holds otherwise. A 32-bit read at offset 0x8 returns it zero-extended.
- R10: Timer status (bit 0) is set whenever the counter MSB changes, both on the 0-to-1 step and on the wrap back to 0.
- R11: `tmr_armed` follows the arm and disarm transitions one clock after the enable bit 0 and status bit 0 values that cause them.
- R12: The enable and control registers store and read back all 16 bits. The status register reads back only bits 0, 5, 8 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pm_base | input | 32 | Window base value from configuration space (masked with 0xFFC0) |
| cfg_decode_on | input | 1 | Window decode enable (configuration control bit 0) |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe; data appears on `io_rdata` after the next edge |
| io_dword | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| io_wdata | input | 16 | Write data for 16-bit writes |
| io_rdata | output | 32 | Registered read data |
| tick_en | input | 1 | Timer advance enable |
| ev_pwrbtn | input | 1 | Power-button event |
| ev_rtc | input | 1 | RTC alarm event |
| ev_gbl | input | 1 | Global-lock release event |
| sci | output | 1 | Level system control interrupt |
| tmr_armed | output | 1 | Timer interrupt armed (state ARM_LIVE) |

## Verification
The decode is tested with the window switched off, with an address one window above the base, and with an aliased offset inside the window. Together these separate the enable gate, the base mask and the 4-bit offset select. Status writes are tested with all-zero data, single-bit data, all-ones data, and a clear in the same cycle as an event, which separates write-one-to-clear, write-zero-keeps and the rule that the event wins. The SCI is tested with a status bit set but its enable clear, with a wide enable pattern that misses the one set status bit, and with a matching pair, which shows the mask and the AND. The timer is run to just below and just past both MSB changes, with enable set and cleared, so the arm rule and the overflow status can be told apart.

// File: rtl/pm1_pkg.sv
`timescale 1ns/1ps
package pm1_pkg;
    // Event bit positions, shared by the status and enable registers
    localparam int BIT_TMR = 0;
    localparam int BIT_GBL = 5;
    localparam int BIT_PWR = 8;
    localparam int BIT_RTC = 10;

    localparam logic [15:0] EVT_MASK = (16'h1 << BIT_TMR) | (16'h1 << BIT_GBL)
                                     | (16'h1 << BIT_PWR) | (16'h1 << BIT_RTC);

    // Register offsets inside the 16-byte repeat
    localparam logic [3:0] OFS_STS = 4'h0;
    localparam logic [3:0] OFS_EN  = 4'h2;
    localparam logic [3:0] OFS_CTL = 4'h4;
    localparam logic [3:0] OFS_TMR = 4'h8;

    typedef enum logic [0:0] {
        ARM_IDLE = 1'b0,
        ARM_LIVE = 1'b1
    } arm_state_e;
endpackage

// File: rtl/pm1_decode.sv
`timescale 1ns/1ps
module pm1_decode #(
    parameter int ADDR_W    = 16,
    parameter int WIN_BYTES = 64
) (
    input  logic [31:0]       cfg_pm_base,
    input  logic              cfg_decode_on,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_dword,
    output logic              hit,
    output logic [3:0]        ofs,
    output logic              wr_sts,
    output logic              wr_en,
    output logic              wr_ctl
);
    import pm1_pkg::*;

    localparam logic [ADDR_W-1:0] WIN_MASK  = ~(ADDR_W'(WIN_BYTES - 1));
    localparam logic [31:0]       BASE_MASK = 32'(WIN_MASK);

    logic [31:0] base_m;
    logic [31:0] addr_m;
    logic        wr_word;

    always_comb begin
        base_m  = cfg_pm_base & BASE_MASK;
        addr_m  = 32'(io_addr) & BASE_MASK;
        hit     = cfg_decode_on && (addr_m == base_m);
        ofs     = io_addr[3:0];
        wr_word = hit && io_wr && !io_dword;
        wr_sts  = wr_word && (ofs == OFS_STS);
        wr_en   = wr_word && (ofs == OFS_EN);
        wr_ctl  = wr_word && (ofs == OFS_CTL);
    end
endmodule

// File: rtl/pm1_regs.sv
`timescale 1ns/1ps
module pm1_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_sts,
    input  logic        wr_en,
    input  logic        wr_ctl,
    input  logic [15:0] wdata,
    input  logic        ev_tmr,
    input  logic        ev_gbl,
    input  logic        ev_pwr,
    input  logic        ev_rtc,
    output logic [15:0] sts_q,
    output logic [15:0] en_q,
    output logic [15:0] ctl_q,
    output logic        sci
);
    import pm1_pkg::*;

    logic [15:0] ev_vec;
    logic [15:0] clr_vec;
    logic [15:0] sts_d;

    always_comb begin
        ev_vec          = '0;
        ev_vec[BIT_TMR] = ev_tmr;
        ev_vec[BIT_GBL] = ev_gbl;
        ev_vec[BIT_PWR] = ev_pwr;
        ev_vec[BIT_RTC] = ev_rtc;
        clr_vec         = wr_sts ? wdata : 16'h0;
        // an event in the same cycle as a clear keeps the bit set
        sts_d           = (ev_vec | (sts_q & ~clr_vec)) & EVT_MASK;
        sci             = |(sts_q & en_q & EVT_MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
            ctl_q <= '0;
        end else begin
            sts_q <= sts_d;
            if (wr_en)  en_q  <= wdata;
            if (wr_ctl) ctl_q <= wdata;
        end
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n) ev_pwr |=> sts_q[BIT_PWR]); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (wr_sts && wdata[BIT_GBL] && !ev_gbl) |=> !sts_q[BIT_GBL]); // R7
    AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (wr_sts && !wdata[BIT_RTC] && sts_q[BIT_RTC]) |=> sts_q[BIT_RTC]); // R7
endmodule

// File: rtl/pm1_timer.sv
`timescale 1ns/1ps
module pm1_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             tmr_en,
    input  logic             tmr_sts,
    output logic [TMR_W-1:0] cnt_q,
    output logic             ovf,
    output logic             armed
);
    import pm1_pkg::*;

    localparam int MSB = TMR_W - 1;

    logic [TMR_W-1:0] cnt_d;
    arm_state_e       state_q;
    arm_state_e       state_d;

    always_comb begin
        cnt_d = tick ? cnt_q + 1'b1 : cnt_q;
        ovf   = tick && (cnt_d[MSB] != cnt_q[MSB]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE: if (tmr_en && !tmr_sts) state_d = ARM_LIVE;
            ARM_LIVE: if (!tmr_en || tmr_sts) state_d = ARM_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARM_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ARM_IDLE: armed = 1'b0;
            ARM_LIVE: armed = 1'b1;
        endcase
    end

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n) tick |=> (cnt_q == $past(cnt_q) + 1'b1)); // R9
    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(cnt_q)); // R9
    AST_ARM_RULE: assert property (@(posedge clk) disable iff (!rst_n) (tmr_en && !tmr_sts) |=> armed); // R11
    AST_DISARM_RULE: assert property (@(posedge clk) disable iff (!rst_n) (!tmr_en || tmr_sts) |=> !armed); // R11
endmodule

// File: rtl/pm1_event_timer.sv
`timescale 1ns/1ps
module pm1_event_timer #(
    parameter int ADDR_W    = 16,
    parameter int WIN_BYTES = 64,
    parameter int TMR_W     = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_pm_base,
    input  logic              cfg_decode_on,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              io_dword,
    input  logic [15:0]       io_wdata,
    output logic [31:0]       io_rdata,
    input  logic              tick_en,
    input  logic              ev_pwrbtn,
    input  logic              ev_rtc,
    input  logic              ev_gbl,
    output logic              sci,
    output logic              tmr_armed
);
    import pm1_pkg::*;

    localparam int PAD_W = 32 - TMR_W;

    logic             hit;
    logic [3:0]       ofs;
    logic             wr_sts;
    logic             wr_en;
    logic             wr_ctl;
    logic [15:0]      sts_q;
    logic [15:0]      en_q;
    logic [15:0]      ctl_q;
    logic [TMR_W-1:0] cnt_q;
    logic             ovf;
    logic [31:0]      rd_val;

    pm1_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_decode (
        .cfg_pm_base  (cfg_pm_base),
        .cfg_decode_on(cfg_decode_on),
        .io_addr      (io_addr),
        .io_wr        (io_wr),
        .io_dword     (io_dword),
        .hit          (hit),
        .ofs          (ofs),
        .wr_sts       (wr_sts),
        .wr_en        (wr_en),
        .wr_ctl       (wr_ctl)
    );

    pm1_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_sts(wr_sts),
        .wr_en (wr_en),
        .wr_ctl(wr_ctl),
        .wdata (io_wdata),
        .ev_tmr(ovf),
        .ev_gbl(ev_gbl),
        .ev_pwr(ev_pwrbtn),
        .ev_rtc(ev_rtc),
        .sts_q (sts_q),
        .en_q  (en_q),
        .ctl_q (ctl_q),
        .sci   (sci)
    );

    pm1_timer #(.TMR_W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_en),
        .tmr_en (en_q[BIT_TMR]),
        .tmr_sts(sts_q[BIT_TMR]),
        .cnt_q  (cnt_q),
        .ovf    (ovf),
        .armed  (tmr_armed)
    );

    always_comb begin
        rd_val = '0;
        if (hit) begin
            if (!io_dword) begin
                unique case (ofs)
                    OFS_STS: rd_val = {16'h0, sts_q};
                    OFS_EN:  rd_val = {16'h0, en_q};
                    OFS_CTL: rd_val = {16'h0, ctl_q};
                    default: rd_val = '0;
                endcase
            end else if (ofs == OFS_TMR) begin
                rd_val = {{PAD_W{1'b0}}, cnt_q};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     io_rdata <= '0;
        else if (io_rd) io_rdata <= rd_val;
    end

    AST_DWORD_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (io_wr && io_dword) |=> ($stable(en_q) && $stable(ctl_q))); // R4
    AST_DECODE_OFF: assert property (@(posedge clk) disable iff (!rst_n) (io_wr && !cfg_decode_on) |=> ($stable(en_q) && $stable(ctl_q))); // R2
    AST_SCI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) sci |-> ((en_q & EVT_MASK) != 16'h0)); // R8
endmodule

// File: tb/tb_pm1_event_timer.sv
`timescale 1ns/1ps
module tb_pm1_event_timer;
    localparam int TMR_W = 10;
    localparam logic [15:0] B = 16'hE400;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg_pm_base;
    logic        cfg_decode_on;
    logic [15:0] io_addr;
    logic        io_wr, io_rd, io_dword;
    logic [15:0] io_wdata;
    logic [31:0] io_rdata;
    logic        tick_en, ev_pwrbtn, ev_rtc, ev_gbl;
    logic        sci, tmr_armed;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pm1_event_timer #(.TMR_W(TMR_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_pm_base(cfg_pm_base), .cfg_decode_on(cfg_decode_on),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_dword(io_dword),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .tick_en(tick_en),
        .ev_pwrbtn(ev_pwrbtn), .ev_rtc(ev_rtc), .ev_gbl(ev_gbl),
        .sci(sci), .tmr_armed(tmr_armed)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_pm_base = 32'hABCD_E437; cfg_decode_on = 1'b1;
        io_addr = '0; io_wr = 0; io_rd = 0; io_dword = 0; io_wdata = '0;
        tick_en = 0; ev_pwrbtn = 0; ev_rtc = 0; ev_gbl = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic dw, input logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_dword = dw; io_wdata = d; io_wr = 1;
        @(negedge clk);
        io_wr = 0; io_dword = 0;
    endtask

    task automatic rd(input logic [15:0] a, input logic dw, output logic [31:0] v);
        @(negedge clk);
        io_addr = a; io_dword = dw; io_rd = 1;
        @(negedge clk);
        io_rd = 0; io_dword = 0;
        v = io_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1;
        repeat (n) @(negedge clk);
        tick_en = 0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        chk("R1 sci", {31'h0, sci}, 0);
        chk("R1 armed", {31'h0, tmr_armed}, 0);
        rd(B + 16'h0, 0, v); chk("R1 status", v, 0);
        rd(B + 16'h2, 0, v); chk("R1 enable", v, 0);
        rd(B + 16'h4, 0, v); chk("R1 control", v, 0);
        rd(B + 16'h8, 1, v); chk("R1 counter", v, 0);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        do_reset();
        cfg_decode_on = 0;
        wr(B + 16'h2, 0, 16'h0120);
        cfg_decode_on = 1;
        rd(B + 16'h2, 0, v); chk("R2 write with decode off", v, 0);
        wr(B + 16'h42, 0, 16'h0020);
        rd(B + 16'h2, 0, v); chk("R2 write above window", v, 0);
        wr(B + 16'h2, 0, 16'h0020);
        rd(B + 16'h2, 0, v); chk("R2 write in window", v, 32'h0020);
        cfg_decode_on = 0;
        rd(B + 16'h2, 0, v); chk("R2 read with decode off", v, 0);
        cfg_decode_on = 1;
        rd(B + 16'h42, 0, v); chk("R2 read above window", v, 0);
    endtask

    task automatic t_offsets();
        logic [31:0] v;
        do_reset();
        wr(B + 16'h2, 0, 16'hFFFF);
        rd(B + 16'h2, 0, v); chk("R12 enable all bits", v, 32'hFFFF);
        wr(B + 16'h4, 0, 16'h1C01);
        rd(B + 16'h4, 0, v); chk("R12 control readback", v, 32'h1C01);
        wr(B + 16'h12, 0, 16'h5A5A);
        rd(B + 16'h2, 0, v); chk("R3 alias write at 0x12", v, 32'h5A5A);
        rd(B + 16'h34, 0, v); chk("R3 alias read at 0x34", v, 32'h1C01);
        ev_pwrbtn = 1; ev_gbl = 1; ev_rtc = 1;
        @(negedge clk);
        ev_pwrbtn = 0; ev_gbl = 0; ev_rtc = 0;
        wr(B + 16'h0, 0, 16'h0000);
        rd(B + 16'h0, 0, v); chk("R12 status implemented bits", v, 32'h0520);
    endtask

    task automatic t_dword();
        logic [31:0] v;
        do_reset();
        wr(B + 16'h2, 0, 16'h0100);
        wr(B + 16'h2, 1, 16'hFFFF);
        rd(B + 16'h2, 0, v); chk("R4 dword write enable", v, 32'h0100);
        wr(B + 16'h4, 1, 16'h1234);
        rd(B + 16'h4, 0, v); chk("R4 dword write control", v, 0);
        ev_pwrbtn = 1; @(negedge clk); ev_pwrbtn = 0;
        wr(B + 16'h0, 1, 16'hFFFF);
        rd(B + 16'h0, 0, v); chk("R4 dword write status", v, 32'h0100);
    endtask

    task automatic t_unimpl();
        logic [31:0] v;
        do_reset();
        wr(B + 16'h2, 0, 16'h0F0F);
        ticks(5);
        rd(B + 16'h6, 0, v); chk("R5 offset 6", v, 0);
        rd(B + 16'h8, 0, v); chk("R5 word read of timer", v, 0);
        rd(B + 16'h2, 1, v); chk("R5 dword read of enable", v, 0);
        rd(B + 16'hC, 1, v); chk("R5 dword read offset C", v, 0);
        rd(B + 16'hF, 0, v); chk("R5 offset F", v, 0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        do_reset();
        ev_pwrbtn = 1; @(negedge clk); ev_pwrbtn = 0;
        rd(B, 0, v); chk("R6 power button bit 8", v, 32'h0100);
        ev_rtc = 1; ev_gbl = 1; @(negedge clk); ev_rtc = 0; ev_gbl = 0;
        rd(B, 0, v); chk("R6 rtc bit 10 and lock bit 5", v, 32'h0520);
        wr(B, 0, 16'h0000);
        rd(B, 0, v); chk("R7 write zero keeps", v, 32'h0520);
        wr(B, 0, 16'h0100);
        rd(B, 0, v); chk("R7 write one clears bit 8", v, 32'h0420);
        @(negedge clk);
        io_addr = B; io_dword = 0; io_wdata = 16'h0400; io_wr = 1; ev_rtc = 1;
        @(negedge clk);
        io_wr = 0; ev_rtc = 0;
        rd(B, 0, v); chk("R7 event wins over clear", v, 32'h0420);
        wr(B, 0, 16'hFFFF);
        rd(B, 0, v); chk("R7 clear all", v, 0);
    endtask

    task automatic t_sci();
        do_reset();
        ev_pwrbtn = 1; @(negedge clk); ev_pwrbtn = 0;
        chk("R8 status without enable", {31'h0, sci}, 0);
        wr(B + 16'h2, 0, 16'h0100);
        chk("R8 power button enabled", {31'h0, sci}, 1);
        wr(B + 16'h2, 0, 16'hFAFE);
        chk("R8 wide enable missing bit 8", {31'h0, sci}, 0);
        ev_gbl = 1; @(negedge clk); ev_gbl = 0;
        chk("R8 global lock enabled", {31'h0, sci}, 1);
        wr(B, 0, 16'hFFFF);
        chk("R8 cleared status drops sci", {31'h0, sci}, 0);
        wr(B + 16'h2, 0, 16'h0400);
        ev_rtc = 1; @(negedge clk); ev_rtc = 0;
        chk("R8 rtc enabled", {31'h0, sci}, 1);
    endtask

    task automatic t_timer();
        logic [31:0] v;
        do_reset();
        ticks(37);
        rd(B + 16'h8, 1, v); chk("R9 count after 37 ticks", v, 37);
        repeat (10) @(negedge clk);
        rd(B + 16'h8, 1, v); chk("R9 hold without tick", v, 37);
        rd(B, 0, v); chk("R10 no status before msb change", v, 0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        do_reset();
        wr(B + 16'h2, 0, 16'h0001);
        @(negedge clk);
        chk("R11 armed after enable", {31'h0, tmr_armed}, 1);
        ticks(511);
        rd(B, 0, v); chk("R10 status clear at 511", v, 0);
        ticks(1);
        rd(B, 0, v); chk("R10 status set on msb rise", v, 32'h0001);
        chk("R8 timer sci", {31'h0, sci}, 1);
        chk("R11 disarmed on status", {31'h0, tmr_armed}, 0);
        rd(B + 16'h8, 1, v); chk("R9 count 512", v, 512);
        wr(B, 0, 16'h0001);
        @(negedge clk);
        chk("R11 rearmed after clear", {31'h0, tmr_armed}, 1);
        ticks(511);
        rd(B, 0, v); chk("R10 status clear at 1023", v, 0);
        ticks(1);
        rd(B, 0, v); chk("R10 status set on wrap", v, 32'h0001);
        rd(B + 16'h8, 1, v); chk("R9 wrapped count", v, 0);
        wr(B, 0, 16'h0001);
        wr(B + 16'h2, 0, 16'h0000);
        @(negedge clk);
        chk("R11 disarmed with enable off", {31'h0, tmr_armed}, 0);
    endtask

    initial begin
        #1_600_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_decode();
        t_offsets();
        t_dword();
        t_unimpl();
        t_events();
        t_sci();
        t_timer();
        t_overflow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule